// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block is the controller for a datapath that lives outside it. It drives a vector of control outputs (mux selects, push and pop strobes, enables) and reads a vector of status inputs (full and empty flags, overflow and underflow flags). Its behaviour comes entirely from a microcode RAM and two small tables. All three can be rewritten through a load port while the sequencer is not running, so one piece of hardware can take on a new control algorithm without being rebuilt.

Each microword is issued in one cycle. It rewrites only the output bits its mask selects and keeps the rest. It then chooses the next address in one of several ways: falling through, jumping, branching on a lookup of the status inputs, a multiway switch through an offset table, or a subroutine call or return on an 8-entry hardware stack. A microword can also load one of four down-counting timers, and the done flags of those timers can be tested like any other status input. A single interrupt redirects fetch to a fixed vector on the next clock edge.

The controller has three states, and the brief names each state and each transition:

- `ST_IDLE` is entered at reset and after a stop word. Here the load port is open. It moves to `ST_RUN` on `start`.
- `ST_RUN` executes one word per cycle. It moves to `ST_IDLE` on a stop word, and to `ST_FAULT` on a stack overflow or underflow.
- `ST_FAULT` holds until reset.

Top module: `useq_core`

## Requirements
- R1: When a microword executes, each bit i of `ctrl_out` takes bit i of the value field if mask bit i is 1, and keeps its previous value if mask bit i is 0. The new value is visible after the clock edge that ends the word's cycle.
- R2: The load port takes one write per cycle when `ld_en` is high. `ld_space` selects the target:
  - 0 is the microcode RAM, written with `ld_data` at `ld_addr`.
  - 1 is condition entry `ld_addr[3:0]`, written with `ld_data[15:0]`.
  - 2 is switch entry `ld_addr[3:0]`, written with `ld_data[9:0]`.
  
  Writes are accepted only while `busy` is low. While running, a write has no effect.
- R3: After reset:
  - `ctrl_out`, `busy` and `fault` are 0, and nothing executes until `start` is sampled high in the idle state.
  - On that edge `busy` rises, and the word at address 0 executes in the following cycle.
  - `ctrl_out` changes only on an edge that ends an executed word.
- R4: The microword fields are laid out as follows:
  - opcode in bits [2:0]
  - select in [6:3]
  - target in [16:7]
  - value in [24:17]
  - mask in [32:25]
  
  The opcodes are NEXT=0, JUMP=1, BRANCH=2, CALL=3, RET=4, SWITCH=5, TLOAD=6 and STOP=7. NEXT, TLOAD and an untaken BRANCH go to address+1, and JUMP goes to the target. STOP applies its outputs and returns to idle.
- R5: CALL pushes address+1 and jumps to the target. RET pops an address and continues there. The stack holds 8 entries.
- R6: The 16-bit status view is divided into lanes of 4 bits:
  - lane 0 is `stat_in[3:0]`
  - lane 1 is `stat_in[7:4]`
  - lane 2 is the timer done flags, timer 3 down to timer 0
  - lane 3 is zero
  
  Select bits [3:2] pick the lane. BRANCH jumps when bit `lane` of condition entry `select` is 1, and falls through otherwise.
- R7: SWITCH continues at target plus switch entry `lane`, modulo 1024.
- R8: TLOAD loads timer `select[1:0]` with the target field. A timer counts down by 1 each cycle while it is nonzero, and its done flag is 1 when it is zero. All timers are zero after reset.
- R9: When `irq` is high in a running cycle and no interrupt is in service:
  - The word of that cycle has no effect, and its address is pushed.
  - The next cycle executes the word at `IRQ_VEC`.
  - `irq` is ignored until a RET pops that interrupt's stack entry.
  
  The interrupted word is executed again after the return.
- R10: A push onto a full stack (by CALL or by the interrupt) or a RET on an empty stack leaves the outputs unchanged. It drops `busy`, raises `fault`, and keeps `fault` high with `start` ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin execution at address 0 when idle |
| irq | input | 1 | Interrupt request |
| stat_in | input | SW (8) | Status inputs from the datapath |
| ld_en | input | 1 | Load port write strobe |
| ld_space | input | 2 | Load target: 0 microcode, 1 condition table, 2 switch table |
| ld_addr | input | AW (10) | Load address |
| ld_data | input | UW (33) | Load data |
| ctrl_out | output | CW (8) | Control outputs to the datapath |
| busy | output | 1 | Sequencer in the running state |
| fault | output | 1 | Sticky stack error |

## Verification
The case most likely to break is an interrupt that lands in the same cycle as a word that itself touches the stack or a timer. Examples are a CALL that is about to push, a RET that is about to pop, or a TLOAD. The interrupt must squash that word whole, and the return must re-execute it exactly once.

To provoke this, the bench runs a program that loops through a subroutine. It fires single-cycle interrupt pulses whose spacing is not a multiple of the loop length, so the pulses sweep across every word of the loop. A behavioural model is compared with the outputs on every clock, and it detects any lost or doubled push, pop or output update.

// File: rtl/useq_pkg.sv
package useq_pkg;
    typedef enum logic [2:0] {
        OP_NEXT   = 3'd0,
        OP_JUMP   = 3'd1,
        OP_BRANCH = 3'd2,
        OP_CALL   = 3'd3,
        OP_RET    = 3'd4,
        OP_SWITCH = 3'd5,
        OP_TLOAD  = 3'd6,
        OP_STOP   = 3'd7
    } useq_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FAULT = 2'd2
    } useq_state_e;

    localparam logic [1:0] SPACE_CODE   = 2'd0;
    localparam logic [1:0] SPACE_COND   = 2'd1;
    localparam logic [1:0] SPACE_SWITCH = 2'd2;

    localparam int OP_W   = 3;
    localparam int SEL_W  = 4;
    localparam int LANE_W = 4;
    localparam int N_LANE = 4;
    localparam int TAB_N  = 16;
endpackage

// File: rtl/useq_ram.sv
module useq_ram #(
    parameter int AW = 10,
    parameter int UW = 33
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [UW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [UW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [UW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/useq_tables.sv
module useq_tables
    import useq_pkg::*;
#(
    parameter int AW = 10,
    parameter int SW = 8,
    parameter int NT = 4
) (
    input  logic                clk,
    input  logic                we_cond,
    input  logic                we_sw,
    input  logic [SEL_W-1:0]    waddr,
    input  logic [TAB_N-1:0]    wdata_cond,
    input  logic [AW-1:0]       wdata_sw,
    input  logic [SW-1:0]       stat_in,
    input  logic [NT-1:0]       tmr_done,
    input  logic [SEL_W-1:0]    sel,
    output logic                cond_hit,
    output logic [AW-1:0]       sw_off
);
    localparam int FLAT_W = N_LANE * LANE_W;

    logic [TAB_N-1:0] cond_tab [TAB_N];
    logic [AW-1:0]    sw_tab   [TAB_N];
    logic [FLAT_W-1:0] flat;
    logic [LANE_W-1:0] lane;

    assign flat = FLAT_W'({tmr_done, stat_in});

    always_comb begin
        lane = flat[sel[SEL_W-1:2]*LANE_W +: LANE_W];
    end

    assign cond_hit = cond_tab[sel][lane];
    assign sw_off   = sw_tab[lane];

    always_ff @(posedge clk) begin
        if (we_cond) cond_tab[waddr] <= wdata_cond;
        if (we_sw)   sw_tab[waddr]   <= wdata_sw;
    end
endmodule

// File: rtl/useq_timers.sv
module useq_timers #(
    parameter int NT = 4,
    parameter int TW = 10,
    localparam int IW = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [IW-1:0] ld_idx,
    input  logic [TW-1:0] ld_val,
    output logic [NT-1:0] done
);
    for (genvar i = 0; i < NT; i++) begin : g_tmr
        logic [TW-1:0] cnt;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cnt <= '0;
            else if (ld && ld_idx == IW'(i))
                cnt <= ld_val;
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
        end

        assign done[i] = (cnt == '0);
    end
endmodule

// File: rtl/useq_core.sv
module useq_core
    import useq_pkg::*;
#(
    parameter int CW      = 8,
    parameter int AW      = 10,
    parameter int SW      = 8,
    parameter int NT      = 4,
    parameter int DEPTH   = 8,
    parameter int IRQ_VEC = 1000,
    parameter int UW      = OP_W + SEL_W + AW + 2 * CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          irq,
    input  logic [SW-1:0] stat_in,
    input  logic          ld_en,
    input  logic [1:0]    ld_space,
    input  logic [AW-1:0] ld_addr,
    input  logic [UW-1:0] ld_data,
    output logic [CW-1:0] ctrl_out,
    output logic          busy,
    output logic          fault
);
    localparam int SEL_LO = OP_W;
    localparam int TGT_LO = SEL_LO + SEL_W;
    localparam int VAL_LO = TGT_LO + AW;
    localparam int MSK_LO = VAL_LO + CW;
    localparam int SPW    = $clog2(DEPTH);
    localparam int TIW    = (NT > 1) ? $clog2(NT) : 1;
    localparam logic [AW-1:0] VEC = AW'(IRQ_VEC);

    useq_state_e state, state_nx;

    logic [UW-1:0]    rd_word;
    logic [AW-1:0]    cur_addr, nxt;
    useq_op_e         op;
    logic [SEL_W-1:0] sel;
    logic [AW-1:0]    tgt;
    logic [CW-1:0]    val, msk;
    logic             running, load_ok, cond_hit;
    logic [AW-1:0]    sw_off;
    logic [NT-1:0]    tmr_done;

    logic [AW-1:0]    stk_addr [DEPTH];
    logic             stk_irq  [DEPTH];
    logic [SPW:0]     sp;
    logic [SPW-1:0]   sp_top;
    logic             stk_full, stk_empty, in_svc;

    logic             irq_take, exe_go, serr, push, pop, stop, tld;
    logic [AW-1:0]    push_addr;
    logic             push_flag;

    assign op  = useq_op_e'(rd_word[OP_W-1:0]);
    assign sel = rd_word[SEL_LO +: SEL_W];
    assign tgt = rd_word[TGT_LO +: AW];
    assign val = rd_word[VAL_LO +: CW];
    assign msk = rd_word[MSK_LO +: CW];

    assign running   = (state == ST_RUN);
    assign load_ok   = ld_en && !running;
    assign stk_full  = (sp == (SPW+1)'(DEPTH));
    assign stk_empty = (sp == '0);
    assign sp_top    = SPW'(sp - 1'b1);
    assign irq_take  = running && irq && !in_svc;
    assign exe_go    = running && !irq_take && !serr;

    useq_ram #(.AW(AW), .UW(UW)) ram_i (
        .clk   (clk),
        .we    (load_ok && ld_space == SPACE_CODE),
        .waddr (ld_addr),
        .wdata (ld_data),
        .raddr (nxt),
        .rdata (rd_word)
    );

    useq_tables #(.AW(AW), .SW(SW), .NT(NT)) tab_i (
        .clk        (clk),
        .we_cond    (load_ok && ld_space == SPACE_COND),
        .we_sw      (load_ok && ld_space == SPACE_SWITCH),
        .waddr      (ld_addr[SEL_W-1:0]),
        .wdata_cond (ld_data[TAB_N-1:0]),
        .wdata_sw   (ld_data[AW-1:0]),
        .stat_in    (stat_in),
        .tmr_done   (tmr_done),
        .sel        (sel),
        .cond_hit   (cond_hit),
        .sw_off     (sw_off)
    );

    useq_timers #(.NT(NT), .TW(AW)) tmr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (tld && exe_go),
        .ld_idx (sel[TIW-1:0]),
        .ld_val (tgt),
        .done   (tmr_done)
    );

    // Next-address selection; the interrupt outranks every word opcode.
    always_comb begin
        nxt       = cur_addr + 1'b1;
        push      = 1'b0;
        pop       = 1'b0;
        push_addr = cur_addr + 1'b1;
        push_flag = 1'b0;
        serr      = 1'b0;
        stop      = 1'b0;
        tld       = 1'b0;
        if (!running) begin
            nxt = '0;
        end else if (irq_take) begin
            if (stk_full) serr = 1'b1;
            else begin
                push      = 1'b1;
                push_addr = cur_addr;
                push_flag = 1'b1;
                nxt       = VEC;
            end
        end else begin
            unique case (op)
                OP_NEXT:   ;
                OP_JUMP:   nxt = tgt;
                OP_BRANCH: if (cond_hit) nxt = tgt;
                OP_CALL: begin
                    if (stk_full) serr = 1'b1;
                    else begin
                        push = 1'b1;
                        nxt  = tgt;
                    end
                end
                OP_RET: begin
                    if (stk_empty) serr = 1'b1;
                    else begin
                        pop = 1'b1;
                        nxt = stk_addr[sp_top];
                    end
                end
                OP_SWITCH: nxt = tgt + sw_off;
                OP_TLOAD:  tld = 1'b1;
                OP_STOP:   stop = 1'b1;
            endcase
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_RUN;
            ST_RUN: begin
                if (serr)      state_nx = ST_FAULT;
                else if (stop) state_nx = ST_IDLE;
            end
            ST_FAULT: state_nx = ST_FAULT;
            default:  state_nx = ST_FAULT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_out <= '0;
            cur_addr <= '0;
            sp       <= '0;
            in_svc   <= 1'b0;
        end else begin
            if (state == ST_IDLE && start) begin
                cur_addr <= '0;
                sp       <= '0;
                in_svc   <= 1'b0;
            end
            if (running && !serr) cur_addr <= nxt;
            if (exe_go) ctrl_out <= (ctrl_out & ~msk) | (val & msk);
            if (push) begin
                stk_addr[sp[SPW-1:0]] <= push_addr;
                stk_irq[sp[SPW-1:0]]  <= push_flag;
                sp <= sp + 1'b1;
                if (push_flag) in_svc <= 1'b1;
            end
            if (pop) begin
                sp <= sp - 1'b1;
                if (stk_irq[sp_top]) in_svc <= 1'b0;
            end
        end
    end

    assign busy  = running;
    assign fault = (state == ST_FAULT);
endmodule

// File: rtl/useq_core_chk.sv
module useq_core_chk #(
    parameter int CW      = 8,
    parameter int AW      = 10,
    parameter int SPW     = 3,
    parameter int DEPTH   = 8,
    parameter int IRQ_VEC = 1000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          fault,
    input logic [CW-1:0] ctrl_out,
    input logic          exe_go,
    input logic [CW-1:0] msk,
    input logic [CW-1:0] val,
    input logic          irq_take,
    input logic          serr,
    input logic [AW-1:0] cur_addr,
    input logic [SPW:0]  sp
);
    a_r1_masked_keep: assert property (@(posedge clk) disable iff (!rst_n)
        exe_go |=> ((ctrl_out & ~$past(msk)) == ($past(ctrl_out) & ~$past(msk))));

    a_r1_masked_set: assert property (@(posedge clk) disable iff (!rst_n)
        exe_go |=> ((ctrl_out & $past(msk)) == ($past(val) & $past(msk))));

    a_r3_hold_unless_exec: assert property (@(posedge clk) disable iff (!rst_n)
        !exe_go |=> $stable(ctrl_out));

    a_r3_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !fault) |=> (busy && cur_addr == '0));

    a_r5_stack_bound: assert property (@(posedge clk) disable iff (!rst_n)
        sp <= (SPW+1)'(DEPTH));

    a_r9_vector_next: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && !serr) |=> (cur_addr == AW'(IRQ_VEC)));

    a_r10_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (fault && !busy));

    a_r10_error_halts: assert property (@(posedge clk) disable iff (!rst_n)
        serr |=> (fault && $stable(ctrl_out)));
endmodule

bind useq_core useq_core_chk #(
    .CW(CW), .AW(AW), .SPW(SPW), .DEPTH(DEPTH), .IRQ_VEC(IRQ_VEC)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .fault    (fault),
    .ctrl_out (ctrl_out),
    .exe_go   (exe_go),
    .msk      (msk),
    .val      (val),
    .irq_take (irq_take),
    .serr     (serr),
    .cur_addr (cur_addr),
    .sp       (sp)
);

// File: tb/useq_core_tb_top.sv
`timescale 1ns/1ps
module useq_core_tb_top;
    localparam int UW = 33;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        irq = 1'b0;
    logic [7:0]  stat_in = '0;
    logic        ld_en = 1'b0;
    logic [1:0]  ld_space = '0;
    logic [9:0]  ld_addr = '0;
    logic [32:0] ld_data = '0;
    logic [7:0]  ctrl_out;
    logic        busy, fault;

    int vectors = 0;
    int miscompares = 0;
    string phase = "R3";
    bit started = 0;

    always #5 clk = ~clk;

    useq_core dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .irq(irq), .stat_in(stat_in),
        .ld_en(ld_en), .ld_space(ld_space), .ld_addr(ld_addr), .ld_data(ld_data),
        .ctrl_out(ctrl_out), .busy(busy), .fault(fault)
    );

    // ---------------- behavioural reference model ----------------
    logic [32:0] m_mem [1024];
    logic [15:0] m_ctab [16];
    logic [9:0]  m_stab [16];
    int          m_tmr [4];
    int          m_stk [$];
    int          m_state = 0;
    int          m_cur = 0;
    bit          m_isv = 0;
    logic [7:0]  m_ctrl = '0;

    int          ost, op, sel, tgt, nx, ld_t, ld_v, e, lane;
    logic [7:0]  wv, wm;
    logic [32:0] w;
    logic [15:0] flat;
    logic [3:0]  td;
    bit          err, go, stp;

    always @(posedge clk) begin
        started = 1;
        ost = m_state;
        if (!rst_n) begin
            m_state = 0; m_cur = 0; m_isv = 0; m_ctrl = '0; m_stk.delete();
            for (int i = 0; i < 4; i++) m_tmr[i] = 0;
        end else begin
            for (int i = 0; i < 4; i++) td[i] = (m_tmr[i] == 0);
            flat = {4'b0, td, stat_in};
            ld_t = -1; ld_v = 0;
            if (m_state == 0) begin
                if (start) begin
                    m_state = 1; m_cur = 0; m_isv = 0; m_stk.delete();
                end
            end else if (m_state == 1) begin
                w = m_mem[m_cur];
                op = int'(w[2:0]); sel = int'(w[6:3]); tgt = int'(w[16:7]);
                wv = w[24:17]; wm = w[32:25];
                lane = int'(flat[sel[3:2]*4 +: 4]);
                nx = (m_cur + 1) % 1024; err = 0; go = 1; stp = 0;
                if (irq && !m_isv) begin
                    go = 0;
                    if (m_stk.size() == 8) err = 1;
                    else begin m_stk.push_back(m_cur | 65536); m_isv = 1; nx = 1000; end
                end else begin
                    case (op)
                        1: nx = tgt;
                        2: if (m_ctab[sel][lane]) nx = tgt;
                        3: if (m_stk.size() == 8) err = 1;
                           else begin m_stk.push_back((m_cur + 1) % 1024); nx = tgt; end
                        4: if (m_stk.size() == 0) err = 1;
                           else begin
                               e = m_stk.pop_back(); nx = e & 1023;
                               if (e >= 65536) m_isv = 0;
                           end
                        5: nx = (tgt + int'(m_stab[lane])) % 1024;
                        6: begin ld_t = sel & 3; ld_v = tgt; end
                        7: stp = 1;
                        default: ;
                    endcase
                end
                if (err) m_state = 2;
                else begin
                    if (go) m_ctrl = (m_ctrl & ~wm) | (wv & wm);
                    m_cur = nx;
                    if (stp) m_state = 0;
                end
            end
            for (int i = 0; i < 4; i++) begin
                if (i == ld_t) m_tmr[i] = ld_v;
                else if (m_tmr[i] > 0) m_tmr[i] = m_tmr[i] - 1;
            end
            if (ld_en && ost != 1) begin
                if (ld_space == 2'd0) m_mem[ld_addr] = ld_data;
                else if (ld_space == 2'd1) m_ctab[ld_addr[3:0]] = ld_data[15:0];
                else if (ld_space == 2'd2) m_stab[ld_addr[3:0]] = ld_data[9:0];
            end
        end
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (started) begin
            vectors++;
            if (ctrl_out !== m_ctrl || busy !== (m_state == 1) || fault !== (m_state == 2)) begin
                miscompares++;
                $display("FAIL %s: actual ctrl=%h busy=%b fault=%b expected ctrl=%h busy=%b fault=%b",
                         phase, ctrl_out, busy, fault, m_ctrl, m_state == 1, m_state == 2);
            end
        end
    end

    // ---------------- helpers ----------------
    function automatic logic [32:0] mw(int o, int s, int t, int v, int m);
        logic [7:0] m8 = m[7:0];
        logic [7:0] v8 = v[7:0];
        logic [9:0] t10 = t[9:0];
        logic [3:0] s4 = s[3:0];
        logic [2:0] o3 = o[2:0];
        return {m8, v8, t10, s4, o3};
    endfunction

    task automatic load(input int sp, input int a, input logic [32:0] d);
        ld_en = 1'b1; ld_space = sp[1:0]; ld_addr = a[9:0]; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic run(output int cyc);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (busy && cyc < 5000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        phase = "R3";
        chk("R3 reset ctrl", int'(ctrl_out), 0);
        chk("R3 reset busy", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // tables
        load(1, 0, 33'h0008);       // cond 0: true when lane0 == 3
        load(1, 1, 33'hFFFE);       // cond 1: true when lane0 != 0
        load(1, 8, 33'hCCCC);       // cond 8: timer1 done
        for (int k = 0; k < 16; k++) load(2, k, 33'(2 * k));

        // R1 / R4 masked update, next, jump, stop
        phase = "R1";
        load(0, 0, mw(0, 0, 0, 8'h0F, 8'hFF));
        load(0, 1, mw(0, 0, 0, 8'hF0, 8'h3C));
        load(0, 2, mw(1, 0, 10, 8'h00, 8'h01));
        load(0, 10, mw(7, 0, 0, 8'h80, 8'h80));
        repeat (2) @(negedge clk);
        chk("R3 idle until start", int'(busy), 0);
        run(cyc);
        chk("R1 masked result", int'(ctrl_out), 'hB2);
        chk("R4 stop returns idle", int'(busy), 0);
        chk("R3 start to stop cycles", cyc, 4);

        // R5 call / return
        phase = "R5";
        load(0, 0, mw(1, 0, 20, 0, 8'hFF));
        load(0, 20, mw(3, 0, 100, 8'h01, 8'hFF));
        load(0, 100, mw(0, 0, 0, 8'h02, 8'h02));
        load(0, 101, mw(4, 0, 0, 8'h04, 8'h04));
        load(0, 21, mw(7, 0, 0, 8'h10, 8'h10));
        run(cyc);
        chk("R5 call return path", int'(ctrl_out), 'h17);

        // R6 branch through condition table
        phase = "R6";
        load(0, 0, mw(1, 0, 30, 0, 8'hFF));
        load(0, 30, mw(2, 0, 40, 0, 0));
        load(0, 31, mw(7, 0, 0, 8'h01, 8'hFF));
        load(0, 40, mw(7, 0, 0, 8'h02, 8'hFF));
        stat_in = 8'h03;
        run(cyc);
        chk("R6 branch taken", int'(ctrl_out), 2);
        stat_in = 8'h05;
        run(cyc);
        chk("R6 branch not taken", int'(ctrl_out), 1);

        // R7 switch
        phase = "R7";
        load(0, 0, mw(1, 0, 50, 0, 8'hFF));
        load(0, 50, mw(5, 4, 60, 0, 0));
        for (int k = 0; k < 4; k++) load(0, 60 + 2 * k, mw(7, 0, 0, 8'h60 + 2 * k, 8'hFF));
        stat_in = 8'h20;
        run(cyc);
        chk("R7 switch lane 2", int'(ctrl_out), 'h64);
        stat_in = 8'h30;
        run(cyc);
        chk("R7 switch lane 3", int'(ctrl_out), 'h66);

        // R8 timer
        phase = "R8";
        stat_in = 8'h00;
        load(0, 0, mw(1, 0, 70, 0, 8'hFF));
        load(0, 70, mw(6, 1, 5, 0, 0));
        load(0, 71, mw(2, 8, 73, 0, 0));
        load(0, 72, mw(1, 0, 71, 0, 0));
        load(0, 73, mw(7, 0, 0, 8'h55, 8'hFF));
        run(cyc);
        chk("R8 timer exit value", int'(ctrl_out), 'h55);
        chk("R8 timer wait cycles", cyc, 10);

        // R9 interrupt sweep, R2 write ignored while running
        phase = "R9";
        load(0, 0, mw(1, 0, 80, 0, 8'hFF));
        load(0, 80, mw(3, 0, 85, 0, 0));
        load(0, 81, mw(2, 1, 83, 0, 0));
        load(0, 82, mw(1, 0, 80, 0, 0));
        load(0, 83, mw(7, 0, 0, 8'h40, 8'h40));
        load(0, 85, mw(0, 0, 0, 8'h01, 8'h01));
        load(0, 86, mw(4, 0, 0, 8'h00, 8'h01));
        load(0, 1000, mw(6, 0, 3, 8'h80, 8'h80));
        load(0, 1001, mw(4, 0, 0, 8'h00, 8'h80));
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        irq = 1'b1;
        repeat (3) @(negedge clk);
        irq = 1'b0;
        phase = "R2";
        load(0, 83, mw(7, 0, 0, 8'h20, 8'h20));
        phase = "R9";
        for (int p = 0; p < 10; p++) begin
            repeat (6) @(negedge clk);
            irq = 1'b1;
            @(negedge clk);
            irq = 1'b0;
        end
        repeat (6) @(negedge clk);
        stat_in = 8'h01;
        cyc = 0;
        while (busy && cyc < 100) begin cyc++; @(negedge clk); end
        chk("R9 final outputs", int'(ctrl_out), 'h40);
        chk("R2 write while running ignored", int'(ctrl_out[5]), 0);

        // R10 overflow
        phase = "R10";
        stat_in = 8'h00;
        load(0, 0, mw(1, 0, 90, 0, 8'hFF));
        load(0, 90, mw(3, 0, 90, 8'h01, 8'h01));
        run(cyc);
        chk("R10 overflow fault", int'(fault), 1);
        chk("R10 overflow cycles", cyc, 10);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk("R10 start ignored", int'(busy), 0);
        chk("R10 fault sticky", int'(fault), 1);

        // R10 underflow after reset
        rst_n = 1'b0;
        @(negedge clk);
        chk("R3 reset clears fault", int'(fault), 0);
        rst_n = 1'b1;
        @(negedge clk);
        load(0, 0, mw(4, 0, 0, 8'hAA, 8'hFF));
        run(cyc);
        chk("R10 underflow fault", int'(fault), 1);
        chk("R10 underflow no output", int'(ctrl_out), 0);

        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule